// File: doc/BRIEF.md
# Script Register Arithmetic Unit

This unit carries out the register arithmetic instruction class of a script-driven I/O sequencer. A 32-bit instruction word is presented together with a one-cycle start strobe. The unit decodes a register number, an immediate byte, an operation and a source/destination mode. When the mode needs it, the unit reads one byte through a byte-wide register port. It then applies one of eight 8-bit operations, and the shifts and additions among them use a persistent carry bit.

The result goes either back to the register port or into the holding register. The holding register stores the first byte the sequencer works on. Both the carry and the holding register keep their values between instructions and are visible as outputs. Instruction words whose mode field this unit does not handle are rejected with a flag, and they leave no side effects.

The controller has five named states:
- IDLE waits for start. A legal mode goes to FETCH, and an unhandled mode goes to REJECT.
- FETCH performs the register read when one is needed and latches the first operand. It always goes on to APPLY.
- APPLY computes the result, drives the register write when one is needed, and updates the carry and the holding register. It always goes on to DONE.
- DONE pulses the done output and returns to IDLE.
- REJECT pulses both done and illegal and returns to IDLE.

Top module: `script_alu_unit`

## Requirements
- R1: The register number is an 8-bit value. Its most significant bit is instruction bit 7, and its low seven bits are instruction bits 22:16. It appears on reg_addr during the read and during the write.
- R2: Mode 5 (instruction bits 29:27 = 101) uses the holding register as the first operand and the immediate byte (bits 15:8) as the second. It performs no register read, writes the result to the addressed register, and leaves the holding register unchanged.
- R3: Mode 6 (110) reads the addressed register as the first operand and uses the immediate byte as the second. It puts the result in the holding register and performs no register write.
- R4: Mode 7 (111) reads the addressed register and writes the result back to it. The second operand is the immediate byte when instruction bit 23 is 0 and the holding register when bit 23 is 1.
- R5: Operation codes are taken from instruction bits 26:24. Move (0) yields the second operand. OR (2), XOR (3) and AND (4) combine the two operands bitwise. All four leave the carry unchanged.
- R6: Shift left (1) puts the old carry into bit 0 and sends the old bit 7 to the carry. Shift right (5) puts the old carry into bit 7 and sends the old bit 0 to the carry.
- R7: Add (6) yields the 8-bit sum and sets the carry exactly when the unsigned sum exceeds 255.
- R8: Add-with-carry (7) adds the old carry as well. It sets the carry on overflow, including the case where the old carry is 1 and the result equals the second operand.
- R9: With start sampled at clock edge E0, reg_rd_en is high for the one cycle after E0 and reg_wr_en for the cycle after that. Done is then high for exactly one cycle. The two enables are never high together.
- R10: Modes 0 to 4 assert illegal and done together for one cycle right after the start edge. They produce no register read or write and leave the carry and the holding register unchanged.
- R11: Start is ignored while an instruction is in progress.
- R12: After reset, the carry and the holding register are 0 and every strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin executing the instruction word |
| instr | input | 32 | Instruction word, sampled with start |
| reg_addr | output | 8 | Register number for the read or the write, 0 otherwise |
| reg_rd_en | output | 1 | Register read strobe |
| reg_rd_data | input | 8 | Register read data, valid in the cycle reg_rd_en is high |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_data | output | 8 | Register write data, 0 when no write is made |
| carry_out | output | 1 | Persistent carry bit |
| hold_out | output | 8 | Holding register |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an unhandled mode |

## Verification
The bench drives addresses that differ only in bit 7. A decoder that dropped or moved that bit would read and write the wrong register.

Add-with-carry is driven into the case where the old carry is 1 and the result equals the second operand. A carry derived from a plain "result below operand" comparison would clear the carry there.

Shifts are run with carry values set up by earlier instructions, so a shift that fed in 0 instead of the carry would show up. Mode 7 is run with the holding register selected as the second operand. A start held high across a busy instruction and rejected modes both check that no state is disturbed: an extra read or write, or a changed carry or holding register, would appear in the cycle-by-cycle comparison.

// File: rtl/salu_pkg.sv
package salu_pkg;

    localparam int INSTR_W = 32;
    localparam int BYTE_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_APPLY,
        ST_DONE,
        ST_REJECT
    } salu_state_e;

    typedef enum logic [2:0] {
        OP_MOVE,
        OP_SHL,
        OP_OR,
        OP_XOR,
        OP_AND,
        OP_SHR,
        OP_ADD,
        OP_ADDC
    } salu_op_e;

    localparam logic [2:0] MODE_FROM_HOLD = 3'd5;
    localparam logic [2:0] MODE_TO_HOLD   = 3'd6;
    localparam logic [2:0] MODE_RMW       = 3'd7;

    typedef struct packed {
        logic [2:0]        mode;
        salu_op_e          op;
        logic              use_hold;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] imm;
    } salu_fields_t;

endpackage

// File: rtl/salu_decode.sv
module salu_decode
    import salu_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output salu_fields_t       fields,
    output logic               handled
);
    always_comb begin
        fields.mode     = word[29:27];
        fields.op       = salu_op_e'(word[26:24]);
        fields.use_hold = word[23];
        // register number: bit 7 on top of bits 22:16
        fields.addr     = {word[7], word[22:16]};
        fields.imm      = word[15:8];
        handled         = (word[29:27] == MODE_FROM_HOLD) ||
                          (word[29:27] == MODE_TO_HOLD)   ||
                          (word[29:27] == MODE_RMW);
    end
endmodule

// File: rtl/salu_core.sv
module salu_core
    import salu_pkg::*;
(
    input  salu_op_e          op,
    input  logic [BYTE_W-1:0] opa,
    input  logic [BYTE_W-1:0] opb,
    input  logic              cin,
    output logic [BYTE_W-1:0] res,
    output logic              cout
);
    logic [BYTE_W:0] sum;

    always_comb begin
        sum  = '0;
        res  = opa;
        cout = cin;
        case (op)
            OP_MOVE: res = opb;
            OP_SHL: begin
                res  = {opa[BYTE_W-2:0], cin};
                cout = opa[BYTE_W-1];
            end
            OP_OR:  res = opa | opb;
            OP_XOR: res = opa ^ opb;
            OP_AND: res = opa & opb;
            OP_SHR: begin
                res  = {cin, opa[BYTE_W-1:1]};
                cout = opa[0];
            end
            OP_ADD: begin
                sum  = {1'b0, opa} + {1'b0, opb};
                res  = sum[BYTE_W-1:0];
                cout = sum[BYTE_W];
            end
            OP_ADDC: begin
                sum  = {1'b0, opa} + {1'b0, opb} + {{BYTE_W{1'b0}}, cin};
                res  = sum[BYTE_W-1:0];
                cout = sum[BYTE_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/script_alu_unit.sv
module script_alu_unit
    import salu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    output logic [BYTE_W-1:0]  reg_addr,
    output logic               reg_rd_en,
    input  logic [BYTE_W-1:0]  reg_rd_data,
    output logic               reg_wr_en,
    output logic [BYTE_W-1:0]  reg_wr_data,
    output logic               carry_out,
    output logic [BYTE_W-1:0]  hold_out,
    output logic               done,
    output logic               illegal
);
    salu_state_e        st, st_nx;
    logic [INSTR_W-1:0] ir;
    salu_fields_t       f_ir, f_in;
    logic               ok_ir, ok_in;
    logic [BYTE_W-1:0]  opa_q, opb, alu_res;
    logic               alu_cout;
    logic               carry_q;
    logic [BYTE_W-1:0]  hold_q;

    salu_decode u_dec_ir (.word(ir),    .fields(f_ir), .handled(ok_ir));
    salu_decode u_dec_in (.word(instr), .fields(f_in), .handled(ok_in));

    assign opb = (f_ir.mode == MODE_RMW && f_ir.use_hold) ? hold_q : f_ir.imm;

    salu_core u_core (
        .op   (f_ir.op),
        .opa  (opa_q),
        .opb  (opb),
        .cin  (carry_q),
        .res  (alu_res),
        .cout (alu_cout)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start) st_nx = ok_in ? ST_FETCH : ST_REJECT;
            ST_FETCH:  st_nx = ST_APPLY;
            ST_APPLY:  st_nx = ST_DONE;
            ST_DONE:   st_nx = ST_IDLE;
            ST_REJECT: st_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir      <= '0;
            opa_q   <= '0;
            carry_q <= 1'b0;
            hold_q  <= '0;
        end else begin
            if (st == ST_IDLE && start) ir <= instr;
            if (st == ST_FETCH)
                opa_q <= (f_ir.mode == MODE_FROM_HOLD) ? hold_q : reg_rd_data;
            if (st == ST_APPLY) begin
                carry_q <= alu_cout;
                if (f_ir.mode == MODE_TO_HOLD) hold_q <= alu_res;
            end
        end
    end

    // outputs
    always_comb begin
        reg_rd_en   = 1'b0;
        reg_wr_en   = 1'b0;
        reg_addr    = '0;
        reg_wr_data = '0;
        done        = 1'b0;
        illegal     = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_FETCH: begin
                reg_rd_en = (f_ir.mode != MODE_FROM_HOLD);
                if (reg_rd_en) reg_addr = f_ir.addr;
            end
            ST_APPLY: begin
                reg_wr_en = (f_ir.mode != MODE_TO_HOLD);
                if (reg_wr_en) begin
                    reg_addr    = f_ir.addr;
                    reg_wr_data = alu_res;
                end
            end
            ST_DONE:   done = 1'b1;
            ST_REJECT: begin
                done    = 1'b1;
                illegal = 1'b1;
            end
        endcase
    end

    assign carry_out = carry_q;
    assign hold_out  = hold_q;

endmodule

// File: rtl/salu_checker.sv
module salu_checker
    import salu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic              done,
    input logic              illegal,
    input logic              carry,
    input logic [BYTE_W-1:0] hold,
    input salu_state_e       st
);
    p_rd_wr_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_write_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (done && !illegal));

    p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !rd_en && !wr_en));

    p_carry_only_in_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_APPLY) |=> $stable(carry));

    p_hold_change_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold) |-> (done && !illegal));
endmodule

bind script_alu_unit salu_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (reg_rd_en),
    .wr_en   (reg_wr_en),
    .done    (done),
    .illegal (illegal),
    .carry   (carry_out),
    .hold    (hold_out),
    .st      (st)
);

// File: tb/sim_script_alu_unit.sv
module sim_script_alu_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] instr;
    logic [7:0]  reg_addr, reg_rd_data, reg_wr_data, hold_out;
    logic        reg_rd_en, reg_wr_en, carry_out, done, illegal;

    always #2 clk = ~clk;

    script_alu_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .reg_addr(reg_addr), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .carry_out(carry_out), .hold_out(hold_out), .done(done), .illegal(illegal)
    );

    logic [7:0] mem [256];
    assign reg_rd_data = reg_rd_en ? mem[reg_addr] : 8'hEE;

    int          compared = 0;
    int          mismatched = 0;
    int          cyc = 0;
    string       cur_req = "R12";
    int          ph;
    logic [31:0] m_ir;
    int          m_a;
    int          m_c, m_h;

    function automatic void calc(input int op, input int a, input int b, input int c,
                                 output int r, output int co);
        co = c;
        case (op)
            0: r = b;
            1: begin r = (a * 2 + c) % 256; co = a / 128; end
            2: r = a | b;
            3: r = a ^ b;
            4: r = a & b;
            5: begin r = a / 2 + c * 128; co = a % 2; end
            6: begin r = (a + b) % 256; co = (r < b) ? 1 : 0; end
            default: begin
                r  = (a + b + c) % 256;
                co = (c != 0) ? ((r <= b) ? 1 : 0) : ((r < b) ? 1 : 0);
            end
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [2:0] mode, input logic [2:0] op,
                                       input logic [7:0] addr, input logic [7:0] imm,
                                       input logic sel);
        return {2'b01, mode, op, sel, addr[6:0], imm, addr[7], 7'b0};
    endfunction

    // reference model and register file, one update per rising edge
    always @(posedge clk) begin
        int mode, r, co, b;
        cyc++;
        if (!rst_n) begin
            ph = 0; m_c = 0; m_h = 0; m_ir = '0; m_a = 0;
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
        end else begin
            if (reg_wr_en) mem[reg_addr] <= reg_wr_data;
            mode = int'(m_ir[29:27]);
            case (ph)
                0: if (start) begin
                    m_ir = instr;
                    ph = (int'(instr[29:27]) >= 5) ? 1 : 4;
                end
                1: begin
                    m_a = (mode == 5) ? m_h : int'(mem[{m_ir[7], m_ir[22:16]}]);
                    ph = 2;
                end
                2: begin
                    b = (mode == 7 && m_ir[23]) ? m_h : int'(m_ir[15:8]);
                    calc(int'(m_ir[26:24]), m_a, b, m_c, r, co);
                    m_c = co;
                    if (mode == 6) m_h = r;
                    ph = 3;
                end
                default: ph = 0;
            endcase
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        int mode, e_rd, e_wr, e_addr, e_wd, r, co, b;
        string q;
        mode = int'(m_ir[29:27]);
        q = rst_n ? cur_req : "R12";
        if (!rst_n) begin
            e_rd = 0; e_wr = 0; e_addr = 0; e_wd = 0;
            check(q, "carry", int'(carry_out), 0);
            check(q, "hold", int'(hold_out), 0);
            check(q, "strobes", int'({reg_rd_en, reg_wr_en, done, illegal}), 0);
        end else begin
            e_rd = (ph == 1 && mode != 5) ? 1 : 0;
            e_wr = (ph == 2 && mode != 6) ? 1 : 0;
            e_addr = (e_rd + e_wr != 0) ? int'({m_ir[7], m_ir[22:16]}) : 0;
            b = (mode == 7 && m_ir[23]) ? m_h : int'(m_ir[15:8]);
            calc(int'(m_ir[26:24]), m_a, b, m_c, r, co);
            e_wd = e_wr ? r : 0;
            check("R9", "reg_rd_en", int'(reg_rd_en), e_rd);
            check("R9", "reg_wr_en", int'(reg_wr_en), e_wr);
            check("R1", "reg_addr", int'(reg_addr), e_addr);
            check(q, "reg_wr_data", int'(reg_wr_data), e_wd);
            check("R9", "done", int'(done), (ph == 3 || ph == 4) ? 1 : 0);
            check("R10", "illegal", int'(illegal), (ph == 4) ? 1 : 0);
            check(q, "carry", int'(carry_out), m_c);
            check(q, "hold", int'(hold_out), m_h);
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic run(input string req, input logic [31:0] w);
        @(negedge clk);
        cur_req = req;
        start = 1'b1;
        instr = w;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        instr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run("R3", mk(3'd6, 3'd0, 8'h12, 8'h5A, 1'b0));   // R3/R5 move immediate into hold
        run("R7", mk(3'd7, 3'd6, 8'h85, 8'hF0, 1'b0));   // R1 high address bit, add
        run("R1", mk(3'd7, 3'd6, 8'h05, 8'h01, 1'b0));   // R1 same low bits, bit 7 clear
        run("R2", mk(3'd5, 3'd0, 8'h30, 8'hFF, 1'b0));   // R2 move immediate to register
        run("R2", mk(3'd5, 3'd3, 8'h31, 8'hDA, 1'b0));   // R2 hold xor immediate: 0x80
        run("R6", mk(3'd7, 3'd1, 8'h31, 8'h00, 1'b0));   // R6 shift left: carry set
        run("R8", mk(3'd7, 3'd7, 8'h30, 8'h20, 1'b0));   // R8 equal case with carry in
        run("R6", mk(3'd7, 3'd5, 8'h44, 8'h00, 1'b0));   // R6 shift right with carry in
        run("R6", mk(3'd7, 3'd1, 8'hC0, 8'h00, 1'b0));   // R6 shift left
        run("R5", mk(3'd7, 3'd2, 8'h50, 8'h0F, 1'b0));   // R5 or
        run("R5", mk(3'd7, 3'd3, 8'h51, 8'hFF, 1'b0));   // R5 xor
        run("R5", mk(3'd7, 3'd4, 8'h52, 8'h3C, 1'b0));   // R5 and
        run("R3", mk(3'd6, 3'd4, 8'h90, 8'hF3, 1'b0));   // R3 and into hold
        run("R4", mk(3'd7, 3'd6, 8'h60, 8'h00, 1'b1));   // R4 hold as second operand
        run("R4", mk(3'd7, 3'd0, 8'h61, 8'h77, 1'b1));   // R4 move hold into register
        run("R7", mk(3'd7, 3'd6, 8'hFE, 8'h01, 1'b0));   // R7 add without overflow
        run("R8", mk(3'd7, 3'd7, 8'h10, 8'h10, 1'b0));   // R8 add with carry
        run("R10", mk(3'd2, 3'd6, 8'h30, 8'h55, 1'b0));  // R10 rejected mode
        run("R10", mk(3'd0, 3'd1, 8'h31, 8'h00, 1'b1));  // R10 rejected mode 0
        // R11: start held high across a busy instruction with another word
        @(negedge clk);
        cur_req = "R11";
        start = 1'b1;
        instr = mk(3'd7, 3'd6, 8'h70, 8'h11, 1'b0);
        @(negedge clk);
        instr = mk(3'd5, 3'd0, 8'h71, 8'hAA, 1'b0);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule